// File: doc/BRIEF.md
# Runtime Parallel-CRC Matrix Builder

This block produces, at runtime, the per-cell configuration bits for a parallel CRC XOR array. A host stores a generator polynomial (the top term is implied and not stored) and a port size, the number of input bits handled per clock, into two holding registers over a simple write port. The host then pulses a start command.

The block then emits one matrix row per clock, along with a one-hot column select that marks which array column should latch that row. Row zero is the stored polynomial taps. Each later row is one LFSR step of the row before it, so only the current row is ever stored. After the last row the block pulses a completion flag and goes quiet. While quiet, it drives all-zero selects and data, so it cannot disturb an array that is already computing CRCs.

Top module: `crcgen_matrix`

## Requirements
- R1: After reset, `busy`, `done` and `row_valid` are 0, and `col_en` and `row_data` are all zero.
- R2: A write with `wr_addr`=0 stores `wr_data` as the polynomial taps. A write with `wr_addr`=1 stores `wr_data[CNT_W-1:0]` as the port size P. A P of 0, or a P larger than PORT_W, is taken as PORT_W.
- R3: A `gen_start` sampled while idle has these effects in the next cycle: `busy`=1, `row_valid`=1, `col_en` bit 0 set, and `row_data` equal to the polynomial taps (row 0).
- R4: Row k+1 is row k shifted left by one place with a 0 entering at bit 0. If bit CRC_W-1 of row k was 1, the polynomial taps are then XORed in.
- R5: `col_en` has exactly one bit set while busy. Row k appears together with `col_en` bit k.
- R6: Exactly P rows are emitted on consecutive cycles. In the cycle after the last row, `done`=1 for one cycle and `busy`=0. For P=32, the rows take 32 cycles and `done` comes in the 33rd cycle.
- R7: A `gen_start` sampled while busy is ignored, and the sequence in progress continues unchanged.
- R8: Writes made while busy update only the holding registers. The sequence in progress keeps the polynomial and port size it started with, and the next start uses the new values.
- R9: While not busy, `row_valid` is 0 and `col_en` and `row_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = polynomial, 1 = port size |
| wr_data | input | CRC_W | Write data |
| gen_start | input | 1 | Start matrix generation |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |
| row_valid | output | 1 | `row_data` carries a matrix row |
| row_data | output | CRC_W | Current matrix row (1 = XOR cell) |
| col_en | output | PORT_W | One-hot column select |

## Verification
The bench samples `gen_start` at a rising edge, and row 0 is visible right after that edge. Row k is therefore due k cycles later, and `done` is due P cycles after the start edge. The bench drives every input on the falling edge and reads the outputs on the next falling edge, half a cycle after they settle. It walks the sequence row by row and compares each row, and each `col_en` value, against a polynomial-step model kept in the bench. Ignored starts and writes made mid-run are injected at a known row index, so the check after them can tell a restart, or a polynomial swap, from a correct continuation.

// File: rtl/crcgen_pkg.sv
package crcgen_pkg;
    typedef enum logic {
        SEL_POLY = 1'b0,
        SEL_PORT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/crcgen_regs.sv
module crcgen_regs
    import crcgen_pkg::*;
#(
    parameter int CRC_W  = 32,
    parameter int PORT_W = 32,
    localparam int CNT_W = $clog2(PORT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CRC_W-1:0] wr_data,
    output logic [CRC_W-1:0] poly_hold,
    output logic [CNT_W-1:0] port_hold
);
    localparam logic [CNT_W-1:0] PMAX = CNT_W'(PORT_W);

    typedef struct packed {
        logic [CRC_W-1:0] poly;
        logic [CNT_W-1:0] port;
    } regs_t;

    regs_t r_q, r_d;
    logic [CNT_W-1:0] port_in;

    always_comb begin
        r_d     = r_q;
        port_in = wr_data[CNT_W-1:0];
        if (wr_en) begin
            if (reg_sel_e'(wr_addr) == SEL_POLY) begin
                r_d.poly = wr_data;
            end else begin
                r_d.port = (port_in == '0 || port_in > PMAX) ? PMAX : port_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.poly <= '0;
            r_q.port <= PMAX;
        end else begin
            r_q <= r_d;
        end
    end

    assign poly_hold = r_q.poly;
    assign port_hold = r_q.port;

    AST_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hold != '0) && (port_hold <= PMAX)); // R2
endmodule

// File: rtl/crcgen_row.sv
module crcgen_row #(
    parameter int CRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CRC_W-1:0] poly_hold,
    output logic [CRC_W-1:0] row
);
    typedef struct packed {
        logic [CRC_W-1:0] row;
        logic [CRC_W-1:0] poly;
    } row_t;

    row_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.row  = poly_hold;
            s_d.poly = poly_hold;
        end else if (step) begin
            s_d.row = {s_q.row[CRC_W-2:0], 1'b0} ^ (s_q.row[CRC_W-1] ? s_q.poly : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign row = s_q.row;

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(row)); // R8
endmodule

// File: rtl/crcgen_seq.sv
module crcgen_seq #(
    parameter int PORT_W = 32,
    localparam int CNT_W = $clog2(PORT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_start,
    input  logic [CNT_W-1:0]  port_hold,
    output logic              load,
    output logic              step,
    output logic              busy,
    output logic              done,
    output logic [PORT_W-1:0] col_en
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  left;
        logic [PORT_W-1:0] col;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        load   = gen_start && !q.busy;
        step   = q.busy && (q.left != '0);
        if (load) begin
            d.busy = 1'b1;
            d.left = port_hold - CNT_W'(1);
            d.col  = PORT_W'(1);
        end else if (q.busy) begin
            if (q.left == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.col  = '0;
            end else begin
                d.left = q.left - CNT_W'(1);
                d.col  = {q.col[PORT_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign col_en = q.col;

    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(col_en) == 1)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (col_en == '0)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && gen_start) |=> (col_en != PORT_W'(1))); // R7
endmodule

// File: rtl/crcgen_matrix.sv
module crcgen_matrix #(
    parameter int CRC_W  = 32,
    parameter int PORT_W = 32,
    localparam int CNT_W = $clog2(PORT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [CRC_W-1:0]  wr_data,
    input  logic              gen_start,
    output logic              busy,
    output logic              done,
    output logic              row_valid,
    output logic [CRC_W-1:0]  row_data,
    output logic [PORT_W-1:0] col_en
);
    logic [CRC_W-1:0] poly_hold;
    logic [CNT_W-1:0] port_hold;
    logic             load, step;
    logic [CRC_W-1:0] row;

    crcgen_regs #(.CRC_W(CRC_W), .PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .poly_hold(poly_hold), .port_hold(port_hold)
    );

    crcgen_seq #(.PORT_W(PORT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .gen_start(gen_start), .port_hold(port_hold),
        .load(load), .step(step), .busy(busy), .done(done), .col_en(col_en)
    );

    crcgen_row #(.CRC_W(CRC_W)) u_row (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .poly_hold(poly_hold), .row(row)
    );

    assign row_valid = busy;
    assign row_data  = busy ? row : '0;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && row_data == '0)); // R6
    AST_START_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && gen_start) |=> (row_valid && col_en[0])); // R3
endmodule

// File: tb/crcgen_matrix_tb.sv
module crcgen_matrix_tb;
    localparam int CRC_W  = 32;
    localparam int PORT_W = 32;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              wr_en = 0;
    logic              wr_addr = 0;
    logic [CRC_W-1:0]  wr_data = '0;
    logic              gen_start = 0;
    logic              busy, done, row_valid;
    logic [CRC_W-1:0]  row_data;
    logic [PORT_W-1:0] col_en;

    int n_chk = 0;
    int n_fail = 0;

    crcgen_matrix #(.CRC_W(CRC_W), .PORT_W(PORT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gen_start(gen_start), .busy(busy), .done(done),
        .row_valid(row_valid), .row_data(row_data), .col_en(col_en)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [CRC_W-1:0] nxt(input logic [CRC_W-1:0] r, input logic [CRC_W-1:0] p);
        return {r[CRC_W-2:0], 1'b0} ^ (r[CRC_W-1] ? p : '0);
    endfunction

    task automatic wr(input logic a, input logic [CRC_W-1:0] v);
        wr_en = 1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic kick();
        gen_start = 1;
        @(negedge clk);
        gen_start = 0;
    endtask

    // Walks a full sequence; optional disturbance at row 'hit'
    task automatic run(input string req, input logic [CRC_W-1:0] p, input int rows,
                       input int hit, input logic [CRC_W-1:0] newp);
        logic [CRC_W-1:0] r;
        r = p;
        kick();
        for (int k = 0; k < rows; k++) begin
            chk({req, " R3/R5 busy"}, 64'(busy), 64'(1));
            chk({req, " R5 col_en"}, 64'(col_en), 64'(PORT_W'(1) << k));
            chk({req, " R4 row"}, 64'(row_data), 64'(r));
            r = nxt(r, p);
            if (k == hit) begin
                gen_start = 1; wr_en = 1; wr_addr = 0; wr_data = newp;
                @(negedge clk);
                gen_start = 0; wr_en = 0;
            end else begin
                @(negedge clk);
            end
        end
        chk({req, " R6 done"}, 64'(done), 64'(1));
        chk({req, " R6 busy low"}, 64'(busy), 64'(0));
        chk({req, " R9 col_en idle"}, 64'(col_en), 64'(0));
        @(negedge clk);
        chk({req, " R6 done pulse"}, 64'(done), 64'(0));
        chk({req, " R9 row_data idle"}, 64'(row_data), 64'(0));
    endtask

    task automatic t_reset();
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 row_valid", 64'(row_valid), 0);
        chk("R1 col_en", 64'(col_en), 0);
        chk("R1 row_data", 64'(row_data), 0);
    endtask

    task automatic t_full32();
        wr(0, 32'h04C1_1DB7);
        wr(1, 32'd32);
        run("R6 P32", 32'h04C1_1DB7, 32, -1, '0);
    endtask

    task automatic t_port8();
        wr(0, 32'h1EDC_6F41);
        wr(1, 32'd8);
        run("R2 P8", 32'h1EDC_6F41, 8, -1, '0);
    endtask

    task automatic t_port_sat();
        wr(0, 32'h8000_0001);
        wr(1, 32'd0);
        run("R2 P0->32", 32'h8000_0001, 32, -1, '0);
        wr(1, 32'd40);
        run("R2 P40->32", 32'h8000_0001, 32, -1, '0);
    endtask

    task automatic t_busy_ignore();
        wr(0, 32'hA5A5_0F0F);
        wr(1, 32'd6);
        run("R7/R8 disturb", 32'hA5A5_0F0F, 6, 2, 32'h0000_00FF);
        run("R8 new poly", 32'h0000_00FF, 6, -1, '0);
    endtask

    task automatic t_zero_poly();
        wr(0, 32'h0);
        wr(1, 32'd1);
        run("R3 P1 zero", 32'h0, 1, -1, '0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset();
                t_full32();
                t_port8();
                t_port_sat();
                t_busy_ignore();
                t_zero_poly();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired actual=hung expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule